// File: doc/BRIEF.md
# Command Ring Free-Space Monitor

This block watches a circular command ring that software fills and a hardware consumer drains. Every cycle it takes in the consumer's read offset (head) and the producer's write offset (tail). It keeps only the bits that address the ring and computes how many bytes the producer may still write. A fixed guard gap is always kept between the producer and the consumer. The block also reports when the two offsets meet, which means the ring is empty.

A client asks for room with a valid/ready request that carries a byte count. A separate drain flag asks for the whole ring less the guard gap, which amounts to waiting until the consumer has caught up. A request that fits is granted in the same cycle. A request that does not fit starts a wait, during which a microsecond tick, derived from the clock by a parameter, paces a stall watchdog. Each tick compares the head with its value at the previous tick. Any movement restarts the count. The watchdog therefore fires a one-cycle error only after the consumer has made no progress for the whole limit, and the block then returns to idle.

Top module: `ring_space_monitor`

## Requirements
- R1: Only bits [RING_LOG2-1:ALIGN_LOG2] of `head_ptr` and `tail_ptr` are used. Bits above the ring size and the low alignment bits have no effect on any output.
- R2: `free_bytes` equals masked head minus (masked tail + GUARD_BYTES). A negative result has the ring size (2^RING_LOG2) added to it, and a result that is still negative reads as 0. The value appears one cycle after the pointers change.
- R3: `ring_empty` is 1 exactly when the masked head equals the masked tail, with the same one-cycle latency as R2.
- R4: `req_ready` is 1 in the same cycle as `req_valid` when the requested byte count is at most `free_bytes`, and 0 when it is larger.
- R5: With `req_drain` set, the requested count is the ring size minus GUARD_BYTES, so the request is granted only when the ring is empty.
- R6: A request that does not fit sets `waiting` from the next cycle. Ticks come every TICK_DIV cycles. If the head does not move for STALL_LIMIT ticks, `stall_err` is raised in cycle STALL_LIMIT*TICK_DIV, counting the entry cycle as cycle 1.
- R7: A head value that differs from the one seen at the previous tick clears the tick count, which delays `stall_err` accordingly.
- R8: `stall_err` lasts one cycle, is never high together with `req_ready`, and `waiting` is 0 in the cycle after it.
- R9: After reset, `waiting`, `req_ready` and `stall_err` are 0, `ring_empty` is 1 and `free_bytes` is the ring size minus GUARD_BYTES.
- R10: When room opens during a wait, `req_ready` rises one cycle after the pointer change, and `waiting` falls after that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| head_ptr | input | PTR_W | Consumer read offset in bytes |
| tail_ptr | input | PTR_W | Producer write offset in bytes |
| req_valid | input | 1 | Room request pending; held until granted or errored |
| req_bytes | input | RING_LOG2+1 | Bytes requested |
| req_drain | input | 1 | Request the full ring less the guard gap |
| req_ready | output | 1 | Request granted this cycle |
| stall_err | output | 1 | One-cycle pulse: consumer stalled for the whole limit |
| waiting | output | 1 | A request is waiting for room |
| free_bytes | output | RING_LOG2+1 | Current free space |
| ring_empty | output | 1 | Head and tail offsets are equal |

## Verification
The pointers are registered once, so `free_bytes` and `ring_empty` are due one cycle after a change. The bench drives pointers on a falling edge and reads these outputs at the next falling edge. A grant is combinational from the registered space and the request inputs, so it is read 1 ns after `req_valid` is driven. After a falling-edge request, the stall error is due in falling-edge interval STALL_LIMIT*TICK_DIV. If the head moves at interval c, the error is due at (k+STALL_LIMIT)*TICK_DIV instead, where k is the first tick with k*TICK_DIV-1 >= c. The bench counts falling edges to land on exactly that interval. It withdraws the request 1 ns after the edge that completes a transfer, so the same request is never granted twice.

// File: rtl/rfm_pkg.sv
package rfm_pkg;
   typedef enum logic {
      RFM_IDLE = 1'b0,
      RFM_WAIT = 1'b1
   } rfm_state_e;
endpackage

// File: rtl/rfm_space_calc.sv
module rfm_space_calc #(
   parameter int PTR_W       = 32,
   parameter int RING_LOG2   = 12,
   parameter int ALIGN_LOG2  = 2,
   parameter int GUARD_BYTES = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [PTR_W-1:0]     head_in,
   input  logic [PTR_W-1:0]     tail_in,
   output logic [RING_LOG2-1:0] head_q,
   output logic [RING_LOG2:0]   free_bytes,
   output logic                 ring_empty
);
   localparam int OFF_W   = RING_LOG2;
   localparam int SPACE_W = RING_LOG2 + 1;
   localparam int DIFF_W  = RING_LOG2 + 2;
   localparam logic [OFF_W-1:0]  KEEP_MASK = ~(OFF_W'((1 << ALIGN_LOG2) - 1));
   localparam logic [DIFF_W-1:0] RING_D    = DIFF_W'(1 << RING_LOG2);
   localparam logic [DIFF_W-1:0] GUARD_D   = DIFF_W'(GUARD_BYTES);
   localparam logic [SPACE_W-1:0] MAX_FREE = SPACE_W'((1 << RING_LOG2) - GUARD_BYTES);

   logic [OFF_W-1:0]  tail_q;
   logic [DIFF_W-1:0] raw_diff;
   logic [DIFF_W-1:0] wrap_diff;
   logic              unused_hi;

   assign unused_hi = ^{head_in[PTR_W-1:OFF_W], tail_in[PTR_W-1:OFF_W]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
      end else begin
         head_q <= head_in[OFF_W-1:0] & KEEP_MASK;
         tail_q <= tail_in[OFF_W-1:0] & KEEP_MASK;
      end
   end

   always_comb begin
      raw_diff  = {2'b00, head_q} - {2'b00, tail_q} - GUARD_D;
      wrap_diff = raw_diff[DIFF_W-1] ? (raw_diff + RING_D) : raw_diff;
      free_bytes = wrap_diff[DIFF_W-1] ? '0 : wrap_diff[SPACE_W-1:0];
   end

   assign ring_empty = (head_q == tail_q);

   p_free_range_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      free_bytes <= MAX_FREE);
   p_empty_free_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      ring_empty |-> (free_bytes == MAX_FREE));
endmodule

// File: rtl/rfm_tick_gen.sv
module rfm_tick_gen #(
   parameter int TICK_DIV = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

   generate
      if (TICK_DIV == 1) begin : g_every_cycle
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign tick = run;
      end else begin : g_divider
         localparam logic [DIV_W-1:0] LAST = DIV_W'(TICK_DIV - 1);
         logic [DIV_W-1:0] div_cnt;
         always_ff @(posedge clk) begin
            if (!rst_n || !run)        div_cnt <= '0;
            else if (div_cnt == LAST)  div_cnt <= '0;
            else                       div_cnt <= div_cnt + 1'b1;
         end
         assign tick = run && (div_cnt == LAST);

         p_div_bound_r6 : assert property (@(posedge clk) disable iff (!rst_n)
            div_cnt <= LAST);
         p_tick_spaced_r6 : assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);
      end
   endgenerate
endmodule

// File: rtl/rfm_stall_timer.sv
module rfm_stall_timer #(
   parameter int HEAD_W      = 12,
   parameter int STALL_LIMIT = 10000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              tick,
   input  logic [HEAD_W-1:0] head_q,
   output logic              expired
);
   localparam int CNT_W = $clog2(STALL_LIMIT + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(STALL_LIMIT - 1);

   logic [CNT_W-1:0]  idle_ticks;
   logic [HEAD_W-1:0] last_head;
   logic              moved;

   assign moved = (head_q != last_head);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idle_ticks <= '0;
         last_head  <= '0;
      end else if (start) begin
         idle_ticks <= '0;
         last_head  <= head_q;
      end else if (tick) begin
         last_head <= head_q;
         if (moved)                   idle_ticks <= '0;
         else if (idle_ticks != LAST) idle_ticks <= idle_ticks + 1'b1;
      end
   end

   assign expired = tick && !moved && (idle_ticks == LAST);

   p_cnt_bound_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      idle_ticks <= LAST);
   p_move_restart_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (tick && moved && !start) |=> (idle_ticks == '0));
endmodule

// File: rtl/ring_space_monitor.sv
module ring_space_monitor #(
   parameter int PTR_W       = 32,
   parameter int RING_LOG2   = 12,
   parameter int ALIGN_LOG2  = 2,
   parameter int GUARD_BYTES = 8,
   parameter int TICK_DIV    = 200,
   parameter int STALL_LIMIT = 10000
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [PTR_W-1:0]     head_ptr,
   input  logic [PTR_W-1:0]     tail_ptr,
   input  logic                 req_valid,
   input  logic [RING_LOG2:0]   req_bytes,
   input  logic                 req_drain,
   output logic                 req_ready,
   output logic                 stall_err,
   output logic                 waiting,
   output logic [RING_LOG2:0]   free_bytes,
   output logic                 ring_empty
);
   import rfm_pkg::*;

   localparam int SPACE_W = RING_LOG2 + 1;
   localparam logic [SPACE_W-1:0] DRAIN_NEED = SPACE_W'((1 << RING_LOG2) - GUARD_BYTES);

   generate
      if (PTR_W <= RING_LOG2) begin : g_bad_ptr_w
         $error("PTR_W must exceed RING_LOG2");
      end
      if (GUARD_BYTES >= (1 << RING_LOG2)) begin : g_bad_guard
         $error("GUARD_BYTES must be below the ring size");
      end
      if (ALIGN_LOG2 >= RING_LOG2) begin : g_bad_align
         $error("ALIGN_LOG2 must be below RING_LOG2");
      end
      if (TICK_DIV < 1 || STALL_LIMIT < 1) begin : g_bad_timer
         $error("TICK_DIV and STALL_LIMIT must be positive");
      end
   endgenerate

   rfm_state_e            state;
   logic [RING_LOG2-1:0]  head_q;
   logic [SPACE_W-1:0]    need;
   logic                  fits;
   logic                  tick;
   logic                  expired;
   logic                  enter_wait;

   rfm_space_calc #(
      .PTR_W(PTR_W), .RING_LOG2(RING_LOG2),
      .ALIGN_LOG2(ALIGN_LOG2), .GUARD_BYTES(GUARD_BYTES)
   ) u_space (
      .clk(clk), .rst_n(rst_n), .head_in(head_ptr), .tail_in(tail_ptr),
      .head_q(head_q), .free_bytes(free_bytes), .ring_empty(ring_empty)
   );

   rfm_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .run(waiting), .tick(tick)
   );

   rfm_stall_timer #(.HEAD_W(RING_LOG2), .STALL_LIMIT(STALL_LIMIT)) u_stall (
      .clk(clk), .rst_n(rst_n), .start(enter_wait), .tick(tick),
      .head_q(head_q), .expired(expired)
   );

   assign need       = req_drain ? DRAIN_NEED : req_bytes;
   assign fits       = (free_bytes >= need);
   assign waiting    = (state == RFM_WAIT);
   assign req_ready  = req_valid && fits;
   assign enter_wait = (state == RFM_IDLE) && req_valid && !fits;
   assign stall_err  = waiting && req_valid && !fits && expired;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= RFM_IDLE;
      end else begin
         unique case (state)
            RFM_IDLE: if (enter_wait) state <= RFM_WAIT;
            RFM_WAIT: if (!req_valid || req_ready || stall_err) state <= RFM_IDLE;
            default:  state <= RFM_IDLE;
         endcase
      end
   end

   p_one_outcome_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      !(req_ready && stall_err));
   p_err_pulse_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      stall_err |=> !stall_err);
   p_err_idle_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      stall_err |=> !waiting);
   p_drain_empty_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready && req_drain) |-> ring_empty);
endmodule

// File: tb/sim_ring_space_monitor.sv
module sim_ring_space_monitor;
   localparam int PW = 16;
   localparam int RL = 8;
   localparam int AL = 2;
   localparam int GB = 8;
   localparam int TD = 4;
   localparam int SL = 10;
   localparam int RING = 1 << RL;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [PW-1:0] head_ptr = '0;
   logic [PW-1:0] tail_ptr = '0;
   logic          req_valid = 1'b0;
   logic [RL:0]   req_bytes = '0;
   logic          req_drain = 1'b0;
   logic          req_ready, stall_err, waiting, ring_empty;
   logic [RL:0]   free_bytes;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   ring_space_monitor #(
      .PTR_W(PW), .RING_LOG2(RL), .ALIGN_LOG2(AL), .GUARD_BYTES(GB),
      .TICK_DIV(TD), .STALL_LIMIT(SL)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .head_ptr(head_ptr), .tail_ptr(tail_ptr),
      .req_valid(req_valid), .req_bytes(req_bytes), .req_drain(req_drain),
      .req_ready(req_ready), .stall_err(stall_err), .waiting(waiting),
      .free_bytes(free_bytes), .ring_empty(ring_empty)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic set_ptrs(input logic [PW-1:0] h, input logic [PW-1:0] t);
      @(negedge clk);
      head_ptr = h;
      tail_ptr = t;
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R9 waiting", waiting, 0);
      chk("R9 req_ready", req_ready, 0);
      chk("R9 stall_err", stall_err, 0);
      chk("R9 ring_empty", ring_empty, 1);
      chk("R9 free_bytes", free_bytes, RING - GB);
   endtask

   task automatic t_free_math();
      set_ptrs(16'h0040, 16'h0010);
      chk("R2 head ahead", free_bytes, 40);
      chk("R3 not empty", ring_empty, 0);
      set_ptrs(16'h0010, 16'h0040);
      chk("R2 wrapped", free_bytes, 200);
      set_ptrs(16'h0000, 16'h00FC);
      chk("R2 clamp", free_bytes, 0);
   endtask

   task automatic t_mask();
      set_ptrs(16'h7F43, 16'h3312);
      chk("R1 masked free", free_bytes, 40);
      set_ptrs(16'h1120, 16'h2223);
      chk("R1 masked empty", ring_empty, 1);
      chk("R3 empty free", free_bytes, RING - GB);
   endtask

   task automatic t_grant_now();
      set_ptrs(16'h0040, 16'h0010);
      req_bytes = 9'd40;
      req_valid = 1'b1;
      #1 chk("R4 exact fit granted", req_ready, 1);
      @(posedge clk);
      #1 req_valid = 1'b0;
      @(negedge clk);
      chk("R4 no wait after grant", waiting, 0);
      req_bytes = 9'd41;
      req_valid = 1'b1;
      #1 chk("R4 one byte over", req_ready, 0);
      @(negedge clk);
      chk("R6 waiting set", waiting, 1);
      req_valid = 1'b0;
      @(negedge clk);
      chk("R6 withdrawn idle", waiting, 0);
   endtask

   task automatic t_stall(input int move_at, input int exp_n, input string tag);
      int n = 0;
      int seen = 0;
      int granted = 0;
      set_ptrs(16'h0040, 16'h0010);
      req_bytes = 9'd100;
      req_valid = 1'b1;
      while (n < 400 && seen == 0) begin
         @(negedge clk);
         n++;
         if (req_ready) granted = 1;
         if (stall_err) seen = 1;
         else if (n == move_at) head_ptr = 16'h0050;
      end
      chk({tag, " error cycle"}, n, exp_n);
      chk("R8 no grant with error", req_ready | granted, 0);
      @(posedge clk);
      #1 req_valid = 1'b0;
      @(negedge clk);
      chk("R8 error one cycle", stall_err, 0);
      chk("R8 idle after error", waiting, 0);
   endtask

   task automatic t_drain();
      set_ptrs(16'h0040, 16'h0010);
      req_drain = 1'b1;
      req_valid = 1'b1;
      #1 chk("R5 drain not empty", req_ready, 0);
      repeat (3) @(negedge clk);
      chk("R10 drain waiting", waiting, 1);
      head_ptr = 16'h0010;
      @(negedge clk);
      chk("R10 grant after drain", req_ready, 1);
      chk("R5 empty at grant", ring_empty, 1);
      @(posedge clk);
      #1 req_valid = 1'b0;
      req_drain = 1'b0;
      @(negedge clk);
      chk("R10 idle after grant", waiting, 0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_free_math();
      t_mask();
      t_grant_now();
      t_stall(0, SL * TD, "R6");
      // head moves at interval 20; first tick to see it is k=6
      t_stall(20, (6 + SL) * TD, "R7");
      t_drain();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule